// File: doc/BRIEF.md
# Sleep-Mode Clock and I/O Power Sequencer

This block moves a small piece of user logic between an awake state and a sleep state. A sleep request first freezes the user logic by dropping the enable of its global clock. One cycle later it powers down the I/O buffers by pulling the output-buffer enable and the input-buffer sleep control low. A wake request undoes these steps in the reverse order: the buffers come back first and the clock enable last. The sequencer runs from an always-on oscillator clock that is never gated.

The user logic is an 8-bit free-running counter, and its value is always visible at the ports. The counter value is captured once while the clock is frozen on the way into sleep, and again on the first enabled cycle on the way out, before the counter has advanced. After a full sleep and wake round the two captures must be equal, which shows that the user logic lost nothing. A general-purpose pad driven from the counter's low bit is released to high impedance while the buffers are powered down. The clock gate is modelled as a synchronous count enable.

Top module: `pwr_sleep_seq`

## Requirements
- R1: A synchronous reset puts the sequencer in the awake phase. It drives the clock enable, output enable and input nsleep high, and clears the counter and both capture registers to 0.
- R2: The counter steps by one, wrapping from 255 to 0, on every oscillator edge where the clock enable is high. It holds its value on every edge where the clock enable is low.
- R3: The request inputs are levels and pass through a two-flop synchroniser. For a sleep request set up before edge 1, the clock enable is still high after edges 1 and 2 and is low after edge 3.
- R4: On the way into sleep, the clock enable falls one oscillator cycle before the output enable and nsleep fall.
- R5: On the way out of sleep, the output enable and nsleep rise one oscillator cycle before the clock enable rises.
- R6: While the output enable is low the pad is high impedance. Otherwise the pad drives bit 0 of the counter value.
- R7: The entry capture stores the counter value while the clock is frozen on entry. The exit capture stores the counter value on the first cycle with the clock re-enabled, before it advances. After a full round the two captures are equal.
- R8: A wake request has no effect unless the sequencer is fully asleep. A sleep request has no effect unless it is fully awake. Each step of the sequence takes one oscillator cycle.
- R9: The output enable and the input nsleep are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Always-running oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Sleep request level, asynchronous |
| wake_req | input | 1 | Wake request level, asynchronous |
| uclk_en | output | 1 | Enable of the user global clock, active high |
| ubuf_oe | output | 1 | Output buffer enable, low in sleep |
| ibuf_nsleep | output | 1 | Input buffer sleep control, low in sleep |
| pad_out | output | 1 | Tri-state pad, high impedance when buffers are off |
| user_count | output | 8 | Present counter value |
| count_at_sleep | output | 8 | Counter value captured on sleep entry |
| count_at_wake | output | 8 | Counter value captured on sleep exit |

## Verification
The case that is hardest to reach is a request that arrives while the sequence is in transit. This covers a wake request during power-down, a sleep request during power-up, and both levels high together so that the block cycles straight back into sleep. Because of the two-flop delay these requests have to be placed in exact cycles. The stimulus holds wake high before sleep is asked for, raises sleep while the block is asleep, and then runs a long stretch of biased random request levels. A behavioural model is compared against the block on every cycle throughout. The counter also runs past its wrap point before any sleep, so that the captured values include a wrapped count.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    PH_AWAKE      = 3'd0,
    PH_GATE_CLK   = 3'd1,
    PH_IO_DOWN    = 3'd2,
    PH_ASLEEP     = 3'd3,
    PH_IO_UP      = 3'd4,
    PH_UNGATE_CLK = 3'd5
  } pwr_phase_e;

  // user clock runs only when fully awake or while being re-enabled
  function automatic logic clk_live(pwr_phase_e p);
    return (p == PH_AWAKE) || (p == PH_UNGATE_CLK);
  endfunction

  // buffers are off only between power-down and power-up steps
  function automatic logic io_live(pwr_phase_e p);
    return !((p == PH_IO_DOWN) || (p == PH_ASLEEP));
  endfunction

  function automatic pwr_phase_e phase_next(pwr_phase_e p, logic go_sleep, logic go_wake);
    case (p)
      PH_AWAKE:      return go_sleep ? PH_GATE_CLK : PH_AWAKE;
      PH_GATE_CLK:   return PH_IO_DOWN;
      PH_IO_DOWN:    return PH_ASLEEP;
      PH_ASLEEP:     return go_wake ? PH_IO_UP : PH_ASLEEP;
      PH_IO_UP:      return PH_UNGATE_CLK;
      default:       return PH_AWAKE;
    endcase
  endfunction
endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go_sleep,
  input  logic       go_wake,
  output pwr_phase_e phase,
  output logic       clk_on,
  output logic       io_on,
  output logic       enter_evt,
  output logic       exit_evt
);
  pwr_phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_AWAKE;
    else     phase_q <= phase_next(phase_q, go_sleep, go_wake);
  end

  assign phase     = phase_q;
  assign clk_on    = clk_live(phase_q);
  assign io_on     = io_live(phase_q);
  assign enter_evt = (phase_q == PH_GATE_CLK);
  assign exit_evt  = (phase_q == PH_UNGATE_CLK);
endmodule

// File: rtl/user_counter.sv
module user_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         snap_in,
  input  logic         snap_out,
  output logic [W-1:0] count,
  output logic [W-1:0] at_sleep,
  output logic [W-1:0] at_wake
);
  function automatic logic [W-1:0] step(logic [W-1:0] v);
    return v + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      at_sleep <= '0;
      at_wake  <= '0;
    end else begin
      if (run)      count    <= step(count);
      if (snap_in)  at_sleep <= count;
      if (snap_out) at_wake  <= count;
    end
  end
endmodule

// File: rtl/pad_buf.sv
module pad_buf (
  input  logic oe,
  input  logic d,
  output tri   pad
);
  assign pad = oe ? d : 1'bz;
endmodule

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_osc,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             wake_req,
  output logic             uclk_en,
  output logic             ubuf_oe,
  output logic             ibuf_nsleep,
  output tri               pad_out,
  output logic [CNT_W-1:0] user_count,
  output logic [CNT_W-1:0] count_at_sleep,
  output logic [CNT_W-1:0] count_at_wake
);
  localparam int NREQ = 2;

  logic [NREQ-1:0] req_raw;
  logic [NREQ-1:0] req_sync_q;
  logic            sleep_sync;
  logic            wake_sync;
  pwr_phase_e      phase;
  logic            clk_on;
  logic            io_on;
  logic            enter_evt;
  logic            exit_evt;

  assign req_raw = {wake_req, sleep_req};

  for (genvar i = 0; i < NREQ; i++) begin : g_sync
    req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk_osc),
      .rst (rst),
      .d   (req_raw[i]),
      .q   (req_sync_q[i])
    );
  end

  assign sleep_sync = req_sync_q[0];
  assign wake_sync  = req_sync_q[1];

  sleep_fsm u_fsm (
    .clk       (clk_osc),
    .rst       (rst),
    .go_sleep  (sleep_sync),
    .go_wake   (wake_sync),
    .phase     (phase),
    .clk_on    (clk_on),
    .io_on     (io_on),
    .enter_evt (enter_evt),
    .exit_evt  (exit_evt)
  );

  user_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk_osc),
    .rst      (rst),
    .run      (clk_on),
    .snap_in  (enter_evt),
    .snap_out (exit_evt),
    .count    (user_count),
    .at_sleep (count_at_sleep),
    .at_wake  (count_at_wake)
  );

  pad_buf u_pad (
    .oe  (io_on),
    .d   (user_count[0]),
    .pad (pad_out)
  );

  assign uclk_en     = clk_on;
  assign ubuf_oe     = io_on;
  assign ibuf_nsleep = io_on;
endmodule

// File: rtl/pwr_sleep_seq_chk.sv
module pwr_sleep_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input pwr_phase_e   phase,
  input logic         sleep_sync,
  input logic         wake_sync,
  input logic         uclk_en,
  input logic         ubuf_oe,
  input logic         exit_evt,
  input logic [W-1:0] user_count,
  input logic [W-1:0] count_at_sleep,
  input logic [W-1:0] count_at_wake
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (phase == PH_AWAKE && uclk_en && ubuf_oe && user_count == '0
             && count_at_sleep == '0 && count_at_wake == '0)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    uclk_en |=> user_count == $past(user_count) + W'(1)); // R2

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !uclk_en |=> $stable(user_count)); // R2

  AST_DOWN_ORDER: assert property (@(posedge clk) disable iff (rst)
    $fell(ubuf_oe) |-> (!uclk_en && !$past(uclk_en))); // R4

  AST_UP_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(uclk_en) |-> (ubuf_oe && $past(ubuf_oe))); // R5

  AST_CAPTURE_MATCH: assert property (@(posedge clk) disable iff (rst)
    exit_evt |=> count_at_wake == count_at_sleep); // R7

  AST_SLEEP_ONLY_AWAKE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_AWAKE && !sleep_sync) |=> phase == PH_AWAKE); // R8

  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ASLEEP && !wake_sync) |=> phase == PH_ASLEEP); // R8
endmodule

bind pwr_sleep_seq pwr_sleep_seq_chk #(.W(CNT_W)) u_chk (
  .clk            (clk_osc),
  .rst            (rst),
  .phase          (phase),
  .sleep_sync     (sleep_sync),
  .wake_sync      (wake_sync),
  .uclk_en        (uclk_en),
  .ubuf_oe        (ubuf_oe),
  .exit_evt       (exit_evt),
  .user_count     (user_count),
  .count_at_sleep (count_at_sleep),
  .count_at_wake  (count_at_wake)
);

// File: tb/pwr_sleep_seq_test.sv
`timescale 1ns/1ps
module pwr_sleep_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0;
  logic wake_req = 1'b0;
  logic uclk_en, ubuf_oe, ibuf_nsleep;
  wire  pad_w;
  logic [7:0] user_count, count_at_sleep, count_at_wake;

  pullup (pad_w);

  always #2.5 clk = ~clk;

  pwr_sleep_seq uut (
    .clk_osc        (clk),
    .rst            (rst),
    .sleep_req      (sleep_req),
    .wake_req       (wake_req),
    .uclk_en        (uclk_en),
    .ubuf_oe        (ubuf_oe),
    .ibuf_nsleep    (ibuf_nsleep),
    .pad_out        (pad_w),
    .user_count     (user_count),
    .count_at_sleep (count_at_sleep),
    .count_at_wake  (count_at_wake)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase index 0 awake .. 5 clock being re-enabled
  int m_ph = 0, m_cnt = 0, m_in = 0, m_out = 0;
  int s1 = 0, s2 = 0, w1 = 0, w2 = 0;
  bit m_rstd = 1, m_round = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_in = 0; m_out = 0;
      s1 = 0; s2 = 0; w1 = 0; w2 = 0; m_rstd = 1; m_round = 0;
    end else begin
      int old;
      old = m_ph;
      m_rstd = 0;
      m_round = (old == 5);
      if (old == 1) m_in = m_cnt;
      if (old == 5) m_out = m_cnt;
      if (old == 0 || old == 5) m_cnt = (m_cnt + 1) % 256;
      if (old == 0) m_ph = s2 ? 1 : 0;
      else if (old == 3) m_ph = w2 ? 4 : 3;
      else m_ph = (old + 1) % 6;
      s2 = s1; s1 = int'(sleep_req);
      w2 = w1; w1 = int'(wake_req);
    end
  end

  always @(negedge clk) if (!done) begin
    int e_clk, e_io, e_pad;
    e_clk = (m_ph == 0 || m_ph == 5) ? 1 : 0;
    e_io  = (m_ph == 2 || m_ph == 3) ? 0 : 1;
    e_pad = e_io ? (m_cnt % 2) : 1;
    if (m_rstd) begin
      chk("R1 clk_en", int'(uclk_en), 1);
      chk("R1 oe", int'(ubuf_oe), 1);
      chk("R1 nsleep", int'(ibuf_nsleep), 1);
      chk("R1 count", int'(user_count), 0);
      chk("R1 cap_in", int'(count_at_sleep), 0);
      chk("R1 cap_out", int'(count_at_wake), 0);
    end else begin
      chk("R4/R5 clk_en", int'(uclk_en), e_clk);
      chk("R4/R5 oe", int'(ubuf_oe), e_io);
      chk("R9 nsleep", int'(ibuf_nsleep), int'(ubuf_oe));
      chk("R2 count", int'(user_count), m_cnt);
      chk("R7 cap_in", int'(count_at_sleep), m_in);
      chk("R7 cap_out", int'(count_at_wake), m_out);
      chk("R6 pad", int'(pad_w), e_pad);
      if (m_round) chk("R7 round match", int'(count_at_wake), int'(count_at_sleep));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_phase(int p);
    int guard = 0;
    while (m_ph != p && guard < 100) begin @(negedge clk); guard++; end
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    // R2: run past the wrap point before any sleep
    cyc(300);

    // R3: exact latency of a sleep request
    sleep_req = 1;
    @(negedge clk); chk("R3 edge1", int'(uclk_en), 1);
    sleep_req = 0;
    @(negedge clk); chk("R3 edge2", int'(uclk_en), 1);
    @(negedge clk); chk("R3 edge3", int'(uclk_en), 0);
    cyc(10);
    wake_req = 1; @(negedge clk); wake_req = 0;
    wait_phase(0); cyc(5);
    chk("R7 captures equal", int'(count_at_wake), int'(count_at_sleep));

    // R8: wake held while awake is ignored
    wake_req = 1;
    cyc(12);
    chk("R8 wake ignored awake", int'(uclk_en), 1);
    // sleep with wake already high: passes through and wakes at once
    sleep_req = 1; @(negedge clk); sleep_req = 0;
    wait_phase(3); @(negedge clk);
    wake_req = 0;
    wait_phase(0); cyc(3);

    // R8: sleep held during sleep is ignored until awake, then re-enters
    sleep_req = 1;
    wait_phase(3);
    cyc(6);
    chk("R8 sleep ignored asleep", int'(ubuf_oe), 0);
    wake_req = 1; @(negedge clk); wake_req = 0;
    wait_phase(0);
    sleep_req = 0;
    wait_phase(3); cyc(4);
    // both levels high together: continuous rounds
    wake_req = 1; sleep_req = 1;
    cyc(60);
    wake_req = 0; sleep_req = 0;
    cyc(20);
    wake_req = 1; cyc(4); wake_req = 0;
    cyc(20);

    // biased random request levels
    for (int i = 0; i < 3000; i++) begin
      sleep_req = ($urandom_range(0, 9) == 0);
      wake_req  = ($urandom_range(0, 6) == 0);
      @(negedge clk);
    end
    sleep_req = 0; wake_req = 0;

    // reset in the middle of sleep
    sleep_req = 1; @(negedge clk); sleep_req = 0;
    wait_phase(3);
    rst = 1; cyc(2); rst = 0;
    cyc(20);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule